// File: doc/BRIEF.md
# Half-Bank Masked-Write Pin Register Block

This block keeps the pin state of a single bank of up to 32 general-purpose pins behind a simple word-addressed register bus. It holds three registers: an output value register, a pin direction register and a separate drive-enable register. It also has a read-only view of the input pins after they pass through a synchronizer. The block sends per-pin output values and per-pin drive enables to the pad wrappers and takes the pad input levels back.

The output value register is written through two write-only half-bank ports. One port covers pins 0 to 15 and the other covers pins 16 to 31. Each word written to a half-bank port carries a 16-bit active-low keep mask in its upper half and 16 new pin values in its lower half. Software can therefore change any subset of sixteen pins in one write, with no read-modify-write. The bank index and the number of pins are parameters. Bank 0 has two pins that cannot be inputs.

Top module: `gpbk_regs`

## Requirements
- R1: After reset the output value and drive-enable registers are 0, and every direction bit is 0 except the locked bits of R9. pin_out_o and pin_oe_o are 0 while reset is held.
- R2: A write to word address 2×BANK_IDX (low-half port) or 2×BANK_IDX+1 (high-half port) updates each pin bit whose mask bit (word bit 16+k) is 0 with data bit k, for pin k or 16+k respectively. Pins whose mask bit is 1 keep their value.
- R3: Reads of the two half-bank ports, and of any word address the bank does not map, return 0. Writes to unmapped addresses change nothing.
- R4: The direction register at word address 0x81+0x10×BANK_IDX is read/write, with 1 meaning output.
- R5: The drive-enable register at word address 0x82+0x10×BANK_IDX is read/write and is independent of the direction register.
- R6: pin_out_o shows the output value register, and pin_oe_o bit n is 1 only when both direction bit n and drive-enable bit n are 1.
- R7: A read of word address 0x18+BANK_IDX returns the pin input levels through a two-flop synchronizer. A change is first visible to a read issued on the third rising edge after the change.
- R8: When W is less than 32, register bits at W and above read as 0 and ignore writes.
- R9: In bank 0, direction bits 7 and 8 are always 1, including after reset and after a write of 0.
- R10: bus_rdata_o is loaded on the rising edge where bus_rd_i is 1. A read and a write to the same register in the same cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | AW | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| pin_in_i | input | W | Pad input levels |
| pin_out_o | output | W | Pin output values |
| pin_oe_o | output | W | Pin drive enables |

## Verification
A read and a write can fall in the same cycle. A write-and-read of one register tests read-before-write ordering. A bus access while the pad inputs change tests the synchronizer delay against the read timing. The random sequence raises both strobes together on the direction and drive-enable registers. The bench expects the value held before the write, then reads again to see the new value. Pad inputs are changed just before back-to-back level reads, and the bench model counts edges to decide which read first sees the new level.

// File: rtl/gpbk_pkg.sv
package gpbk_pkg;

  localparam int unsigned HALF_W = 16;
  localparam int unsigned WORD_W = 32;

  // Keep bits where the mask half is 1, take new data where it is 0.
  function automatic logic [HALF_W-1:0] half_merge(input logic [HALF_W-1:0] old_v,
                                                   input logic [WORD_W-1:0] word);
    logic [HALF_W-1:0] keep;
    keep = word[WORD_W-1:HALF_W];
    return (old_v & keep) | (word[HALF_W-1:0] & ~keep);
  endfunction

  function automatic logic [WORD_W-1:0] width_mask(input int unsigned w);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < WORD_W; i++) if (i < w) m[i] = 1'b1;
    return m;
  endfunction

  // Direction bits that can never be cleared.
  function automatic logic [WORD_W-1:0] lock_mask(input int unsigned bank, input int unsigned w);
    logic [WORD_W-1:0] m;
    m = '0;
    if (bank == 0) begin
      if (w > 7) m[7] = 1'b1;
      if (w > 8) m[8] = 1'b1;
    end
    return m;
  endfunction

  function automatic int unsigned lo_port_word(input int unsigned bank);
    return 2 * bank;
  endfunction

  function automatic int unsigned hi_port_word(input int unsigned bank);
    return 2 * bank + 1;
  endfunction

  function automatic int unsigned level_word(input int unsigned bank);
    return 24 + bank;
  endfunction

  function automatic int unsigned dir_word(input int unsigned bank);
    return 129 + 16 * bank;
  endfunction

  function automatic int unsigned oen_word(input int unsigned bank);
    return 130 + 16 * bank;
  endfunction

endpackage

// File: rtl/gpbk_sync.sv
module gpbk_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= d_i[i];
        s2 <= s1;
      end
    end
    assign q_o[i] = s2;
  end
endmodule

// File: rtl/gpbk_cfg_reg.sv
module gpbk_cfg_reg #(
  parameter logic [31:0] IMPL   = 32'hFFFF_FFFF,
  parameter logic [31:0] FORCE1 = 32'h0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] q_o
);
  always_ff @(posedge clk_i) begin
    if (!rst_ni)   q_o <= FORCE1;
    else if (wr_i) q_o <= (wdata_i & IMPL) | FORCE1;
  end
endmodule

// File: rtl/gpbk_outdata.sv
module gpbk_outdata import gpbk_pkg::*; #(
  parameter logic [31:0] IMPL = 32'hFFFF_FFFF
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_lo_i,
  input  logic        wr_hi_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] q_o
);
  for (genvar h = 0; h < 2; h++) begin : g_half
    localparam logic [HALF_W-1:0] HMASK = IMPL[h*HALF_W +: HALF_W];
    logic hit;
    logic [HALF_W-1:0] val;
    assign hit = (h == 0) ? wr_lo_i : wr_hi_i;
    always_ff @(posedge clk_i) begin
      if (!rst_ni)  val <= '0;
      else if (hit) val <= half_merge(val, wdata_i) & HMASK;
    end
    assign q_o[h*HALF_W +: HALF_W] = val;
  end
endmodule

// File: rtl/gpbk_regs.sv
module gpbk_regs import gpbk_pkg::*; #(
  parameter int unsigned BANK_IDX = 0,
  parameter int unsigned W        = 32,
  parameter int unsigned AW       = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_wr_i,
  input  logic          bus_rd_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [31:0]   bus_wdata_i,
  output logic [31:0]   bus_rdata_o,
  input  logic [W-1:0]  pin_in_i,
  output logic [W-1:0]  pin_out_o,
  output logic [W-1:0]  pin_oe_o
);
  localparam logic [31:0]   IMPL  = width_mask(W);
  localparam logic [31:0]   LOCK  = lock_mask(BANK_IDX, W);
  localparam logic [AW-1:0] A_LO  = AW'(lo_port_word(BANK_IDX));
  localparam logic [AW-1:0] A_HI  = AW'(hi_port_word(BANK_IDX));
  localparam logic [AW-1:0] A_LVL = AW'(level_word(BANK_IDX));
  localparam logic [AW-1:0] A_DIR = AW'(dir_word(BANK_IDX));
  localparam logic [AW-1:0] A_OEN = AW'(oen_word(BANK_IDX));

  // Decoded events, named for the checker.
  logic wr_lo_hit, wr_hi_hit, wr_dir_hit, wr_oen_hit;
  assign wr_lo_hit  = bus_wr_i && (bus_addr_i == A_LO);
  assign wr_hi_hit  = bus_wr_i && (bus_addr_i == A_HI);
  assign wr_dir_hit = bus_wr_i && (bus_addr_i == A_DIR);
  assign wr_oen_hit = bus_wr_i && (bus_addr_i == A_OEN);

  logic [31:0] out_q, dir_q, oen_q, lvl_q;
  logic [W-1:0] lvl_w;

  gpbk_outdata #(.IMPL(IMPL)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_lo_i (wr_lo_hit),
    .wr_hi_i (wr_hi_hit),
    .wdata_i (bus_wdata_i),
    .q_o     (out_q)
  );

  gpbk_cfg_reg #(.IMPL(IMPL), .FORCE1(LOCK)) u_dir (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_dir_hit),
    .wdata_i (bus_wdata_i),
    .q_o     (dir_q)
  );

  gpbk_cfg_reg #(.IMPL(IMPL), .FORCE1(32'h0)) u_oen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_oen_hit),
    .wdata_i (bus_wdata_i),
    .q_o     (oen_q)
  );

  gpbk_sync #(.W(W)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_in_i),
    .q_o    (lvl_w)
  );

  assign lvl_q = 32'(lvl_w);

  logic [31:0] rd_mux;
  always_comb begin
    if (bus_addr_i == A_LVL)      rd_mux = lvl_q;
    else if (bus_addr_i == A_DIR) rd_mux = dir_q;
    else if (bus_addr_i == A_OEN) rd_mux = oen_q;
    else                          rd_mux = '0;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)       bus_rdata_o <= '0;
    else if (bus_rd_i) bus_rdata_o <= rd_mux;
  end

  assign pin_out_o = out_q[W-1:0];
  assign pin_oe_o  = dir_q[W-1:0] & oen_q[W-1:0];

endmodule

// File: rtl/gpbk_regs_chk.sv
module gpbk_regs_chk import gpbk_pkg::*; #(
  parameter int unsigned BANK_IDX = 0,
  parameter int unsigned W        = 32,
  parameter int unsigned AW       = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bus_rd_i,
  input logic [AW-1:0] bus_addr_i,
  input logic [31:0]   bus_wdata_i,
  input logic [31:0]   bus_rdata_o,
  input logic [W-1:0]  pin_in_i,
  input logic [W-1:0]  pin_oe_o,
  input logic          wr_lo_hit,
  input logic          wr_dir_hit,
  input logic [31:0]   out_q,
  input logic [31:0]   dir_q,
  input logic [31:0]   lvl_q
);
  localparam logic [31:0]   IMPL = width_mask(W);
  localparam logic [31:0]   LOCK = lock_mask(BANK_IDX, W);
  localparam logic [AW-1:0] A_LO = AW'(lo_port_word(BANK_IDX));
  localparam logic [AW-1:0] A_HI = AW'(hi_port_word(BANK_IDX));

  logic [1:0] up_cnt;
  always_ff @(posedge clk_i) begin
    if (!rst_ni)              up_cnt <= '0;
    else if (up_cnt != 2'd3)  up_cnt <= up_cnt + 2'd1;
  end

  a_r2_keep_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_hit |=> ((out_q[15:0] & $past(bus_wdata_i[31:16])) ==
                   ($past(out_q[15:0]) & $past(bus_wdata_i[31:16]))));

  a_r3_port_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && (bus_addr_i == A_LO || bus_addr_i == A_HI)) |=> (bus_rdata_o == 32'h0));

  a_r4_dir_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_dir_hit |=> $stable(dir_q));

  a_r6_oe_needs_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_oe_o & ~dir_q[W-1:0]) == '0);

  a_r7_sync_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_cnt >= 2'd2) |-> (lvl_q == 32'($past(pin_in_i, 2))));

  a_r8_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((bus_rdata_o | out_q | dir_q) & ~IMPL) == 32'h0);

  a_r9_dir_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_dir_hit |=> (((dir_q ^ $past(bus_wdata_i)) & IMPL & ~LOCK) == 32'h0) &&
                   ((dir_q & LOCK) == LOCK));
endmodule

bind gpbk_regs gpbk_regs_chk #(.BANK_IDX(BANK_IDX), .W(W), .AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_rd_i    (bus_rd_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .pin_in_i    (pin_in_i),
  .pin_oe_o    (pin_oe_o),
  .wr_lo_hit   (wr_lo_hit),
  .wr_dir_hit  (wr_dir_hit),
  .out_q       (out_q),
  .dir_q       (dir_q),
  .lvl_q       (lvl_q)
);

// File: tb/gpbk_regs_test.sv
module gpbk_regs_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic        wr = 1'b0, rd = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] pin = '0;
  logic [31:0] rd_a, rd_b, po_a, oe_a;
  logic [21:0] po_b, oe_b;

  gpbk_regs #(.BANK_IDX(0), .W(32), .AW(10)) uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rd_a), .pin_in_i(pin),
    .pin_out_o(po_a), .pin_oe_o(oe_a));

  gpbk_regs #(.BANK_IDX(1), .W(22), .AW(10)) uut_narrow (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rd_b), .pin_in_i(pin[21:0]),
    .pin_out_o(po_b), .pin_oe_o(oe_b));

  int total = 0, bad = 0;
  logic [31:0] m_out [2];
  logic [31:0] m_dir [2];
  logic [31:0] m_oen [2];
  logic [31:0] m_lvl;

  function automatic logic [31:0] wmask(int i);
    return (i == 0) ? 32'hFFFF_FFFF : 32'h003F_FFFF;
  endfunction

  function automatic logic [31:0] lockm(int i);
    return (i == 0) ? 32'h0000_0180 : 32'h0;
  endfunction

  function automatic logic [31:0] exp_read(int i, logic [9:0] a);
    if (a == 10'(24 + i))       return m_lvl & wmask(i);
    if (a == 10'(129 + 16 * i)) return m_dir[i];
    if (a == 10'(130 + 16 * i)) return m_oen[i];
    return 32'h0;
  endfunction

  task automatic model_wr(logic [9:0] a, logic [31:0] d);
    for (int i = 0; i < 2; i++) begin
      if (a == 10'(2 * i) || a == 10'(2 * i + 1)) begin
        int base = (a == 10'(2 * i + 1)) ? 16 : 0;
        for (int b = 0; b < 16; b++)
          if (!d[16 + b] && wmask(i)[base + b]) m_out[i][base + b] = d[b];
      end
      if (a == 10'(129 + 16 * i)) m_dir[i] = (d & wmask(i)) | lockm(i);
      if (a == 10'(130 + 16 * i)) m_oen[i] = d & wmask(i);
    end
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_pins();
    check("R6 out bank0", po_a, m_out[0]);
    check("R6 oe bank0", oe_a, m_dir[0] & m_oen[0]);
    check("R6 R8 out narrow", 32'(po_b), m_out[1]);
    check("R6 R8 oe narrow", 32'(oe_b), m_dir[1] & m_oen[1]);
  endtask

  task automatic bus(bit dw, bit dr, logic [9:0] a, logic [31:0] d, string tag);
    logic [31:0] e0, e1;
    @(negedge clk);
    wr = dw; rd = dr; addr = a; wdata = d;
    e0 = exp_read(0, a);
    e1 = exp_read(1, a);
    @(posedge clk);
    #1;
    wr = 1'b0; rd = 1'b0;
    if (dw) model_wr(a, d);
    if (dr) begin
      check({tag, " bank0"}, rd_a, e0);
      check({tag, " narrow"}, rd_b, e1);
    end
    check_pins();
  endtask

  initial begin
    #(CLK_P * 150000);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 2; i++) begin
      m_out[i] = '0; m_dir[i] = lockm(i); m_oen[i] = '0;
    end
    m_lvl = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 out in reset", po_a, 32'h0);
    check("R1 oe in reset", oe_a, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 / R9 reset values
    bus(0, 1, 10'd129, 0, "R1 R9 dir reset");
    bus(0, 1, 10'd130, 0, "R1 oen reset");
    bus(0, 1, 10'd145, 0, "R1 dir reset");

    // R7 synchronizer latency
    pin = 32'hA5C3_0F1E;
    bus(0, 1, 10'd24, 0, "R7 level first edge");
    bus(0, 1, 10'd24, 0, "R7 level second edge");
    m_lvl = pin;
    bus(0, 1, 10'd24, 0, "R7 level third edge");
    bus(0, 1, 10'd25, 0, "R7 R8 narrow level");

    // R2 masked writes
    bus(1, 0, 10'd0, 32'hFFFF_FFFF, "R2 all kept");
    bus(1, 0, 10'd0, 32'h0000_1234, "R2 low all taken");
    bus(1, 0, 10'd1, 32'hFF00_00AB, "R2 high partial");
    bus(1, 0, 10'd0, 32'hFFFE_0000, "R2 single pin 0");
    bus(1, 0, 10'd3, 32'h0000_FFFF, "R2 R8 narrow high");

    // R4 / R5 / R6 / R8 / R9
    bus(1, 0, 10'd129, 32'h0000_0000, "R9 clear dir");
    bus(0, 1, 10'd129, 0, "R9 locked dir");
    bus(1, 0, 10'd130, 32'hFFFF_FFFF, "R5 oen set");
    bus(1, 0, 10'd129, 32'h0F0F_0F0F, "R4 dir");
    bus(1, 0, 10'd145, 32'hFFFF_FFFF, "R8 narrow dir");
    bus(0, 1, 10'd145, 0, "R8 narrow dir read");
    bus(1, 0, 10'd146, 32'h00F0_00F0, "R5 narrow oen");

    // R3 write-only ports and unmapped
    bus(0, 1, 10'd0, 0, "R3 low port read");
    bus(0, 1, 10'd1, 0, "R3 high port read");
    bus(1, 1, 10'd400, 32'hDEAD_BEEF, "R3 unmapped");

    // R10 same-cycle read and write
    bus(1, 1, 10'd130, 32'h1234_5678, "R10 rw oen old");
    bus(0, 1, 10'd130, 0, "R10 rw oen new");
    bus(1, 1, 10'd145, 32'h0000_0001, "R10 rw narrow dir old");
    bus(0, 1, 10'd145, 0, "R10 rw narrow dir new");

    // random mix
    for (int n = 0; n < 600; n++) begin
      int i = int'($urandom % 2);
      int op = int'($urandom % 8);
      logic [31:0] d = $urandom;
      case (op)
        0: bus(1, 0, 10'(2 * i), d, "R2 rand low");
        1: bus(1, 0, 10'(2 * i + 1), d, "R2 rand high");
        2: bus(1, 0, 10'(129 + 16 * i), d, "R4 R9 rand dir");
        3: bus(1, 0, 10'(130 + 16 * i), d, "R5 rand oen");
        4: bus(0, 1, (d[0] ? 10'(24 + i) : (d[1] ? 10'(129 + 16 * i) : 10'(130 + 16 * i))),
               0, "R4/R5/R7 rand read");
        5: bus(1, 1, (d[2] ? 10'(129 + 16 * i) : 10'(130 + 16 * i)), d, "R10 rand rw");
        6: bus(0, 1, 10'(2 * i + (d[3] ? 1 : 0)), 0, "R3 rand port read");
        default: bus(d[4], 1, 10'($urandom), d, "R3 rand addr");
      endcase
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule